// File: doc/BRIEF.md
# Serial SRAM Slave with Burst Modes

This block is the slave side of an SPI-attached byte memory of 8K x 8 bits. A host selects it by pulling chip select low, shifts an 8-bit instruction in on the data input, and then moves data through either the memory array or a one-byte configuration register. The configuration register holds a two-bit burst-mode field and a bit that turns the pause (hold) input on or off.

All four pins are oversampled by the block's system clock through two-stage synchronizers. Serial clock edges are found from the synchronized samples, so the serial clock half-period must span at least four system clocks. The interface uses SPI mode 0. The input is taken on the rising serial clock edge, and the output changes on the falling edge, most significant bit first. The serial output comes with an enable that marks when it is actually driven, so the pad can be tri-stated when the enable is low.

A read or write instruction is followed by a 16-bit address. Only the low 13 bits select a byte. The mode field then decides what happens after the first data byte. In single-byte mode the transfer ends. In page mode the address wraps inside an aligned 32-byte page. In sequential mode the address runs over the whole array and wraps at the top.

Top module: `spi_sram_slave`

## Requirements
- R1: After reset the configuration byte reads 0x02: mode field 00 (single-byte), pause function enabled (bit 0 = 0). The output enable is low.
- R2: Instruction 0x05 returns the configuration byte, MSB first, on the 8 clocks after the instruction. Layout: bits 7:6 mode, bits 5:2 zero, bit 1 one, bit 0 pause-disable. The output enable stays low during the 8 instruction clocks.
- R3: Instruction 0x01 followed by one byte updates only bits 7:6 and bit 0. Bits 5:2 always read 0 and bit 1 always reads 1, whatever was written.
- R4: Instruction 0x02 writes and 0x03 reads. Each is followed by a 16-bit address, MSB first, whose upper 3 bits are ignored. The output enable stays low through the instruction and the address.
- R5: In mode 00, and in the reserved mode 11, a read or write moves exactly one byte. Later clocks in the same transfer neither store data nor drive the output.
- R6: In mode 10 (page) the address of each following byte increments within its aligned 32-byte page, wrapping from offset 31 to offset 0.
- R7: In mode 01 (sequential) the address increments over the whole array, wrapping from 0x1FFF to 0x0000.
- R8: With pause enabled (bit 0 = 0), pulling hold_n low while the serial clock is low makes the output enable low. Serial clock and data are then ignored until hold_n returns high, and the transfer resumes where it stopped.
- R9: With pause disabled (bit 0 = 1), hold_n has no effect on the transfer.
- R10: Raising chip select aborts any transfer, forces the output enable low and restarts the bit count. An unknown instruction is ignored until chip select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host, idle low |
| si | input | 1 | Serial data into the block |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | High when so is driven; low means high-impedance |

## Verification
The bound checker watches, on every cycle, the properties that hold at all times. Chip select held high keeps the output undriven. While paused, the output is undriven and the bit count is frozen. A pause can only begin when the register enables it. The mode and pause bits change only on a completed configuration write. A memory write happens only inside a selected transfer. Byte ordering, address wrap at page and array boundaries, the fixed bits of the configuration readback, single-byte termination, resumption after a pause and recovery after an abort all depend on data values and sequences, so only the bench's scenarios can show them; its scoreboard compares every returned byte against values derived from the requirements.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;

    typedef enum logic [2:0] {
        PH_CMD   = 3'd0,
        PH_ADDR  = 3'd1,
        PH_WDATA = 3'd2,
        PH_RDATA = 3'd3,
        PH_WCFG  = 3'd4,
        PH_IDLE  = 3'd5
    } phase_e;

    localparam logic [7:0] OP_WR_CFG = 8'h01;
    localparam logic [7:0] OP_WRITE  = 8'h02;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_RD_CFG = 8'h05;

    localparam logic [1:0] MD_BYTE = 2'b00;
    localparam logic [1:0] MD_SEQ  = 2'b01;
    localparam logic [1:0] MD_PAGE = 2'b10;
    localparam logic [1:0] MD_RSVD = 2'b11;

endpackage

// File: rtl/spi_sram_sync.sv
module spi_sram_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/spi_sram_mem.sv
module spi_sram_mem #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells_q[addr] <= wdata;
        end
    end

    assign rdata = cells_q[addr];

endmodule

// File: rtl/spi_sram_ctrl.sv
module spi_sram_ctrl
    import spi_sram_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int CMD_ADDR_W = 16,
    parameter int PAGE_BYTES = 32,
    parameter int CNT_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              si_s,
    input  logic              hold_n_s,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic              so,
    output logic              so_oe,
    output logic              held,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic [1:0]        mode,
    output logic              hold_dis,
    output logic              cfg_wr
);

    localparam int               PAGE_W    = $clog2(PAGE_BYTES);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(7);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(CMD_ADDR_W - 1);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [6:0]        sh;
        logic [7:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        out_sh;
        logic              first;
        logic              so;
        logic              oe;
        logic              held;
        logic              sck_prev;
        logic [1:0]        mode;
        logic              hold_dis;
    } state_t;

    state_t q, d;
    logic   we_d;
    logic   cfg_wr_d;
    logic [7:0] wdata_d;

    function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                     input logic [1:0] md);
        logic [ADDR_W-1:0] n;
        n = a;
        if (md == MD_PAGE) begin
            n[PAGE_W-1:0] = a[PAGE_W-1:0] + PAGE_W'(1);
        end else begin
            n = a + ADDR_W'(1);
        end
        return n;
    endfunction

    always_comb begin
        logic       rise;
        logic       fall;
        logic       single;
        logic [7:0] sh_in;
        logic [7:0] cfg_byte;
        logic [7:0] src;

        d        = q;
        we_d     = 1'b0;
        cfg_wr_d = 1'b0;

        rise     = sck_s & ~q.sck_prev;
        fall     = ~sck_s & q.sck_prev;
        sh_in    = {q.sh, si_s};
        wdata_d  = sh_in;
        cfg_byte = {q.mode, 4'b0000, 1'b1, q.hold_dis};
        single   = (q.mode == MD_BYTE) || (q.mode == MD_RSVD);
        src      = (q.op == OP_RD_CFG) ? cfg_byte : mem_rdata;

        d.sck_prev = sck_s;

        if (cs_n_s) begin
            d.ph    = PH_CMD;
            d.cnt   = '0;
            d.oe    = 1'b0;
            d.held  = 1'b0;
            d.first = 1'b0;
        end else begin
            if (!q.held) begin
                if (rise) begin
                    case (q.ph)
                        PH_CMD: begin
                            d.sh  = sh_in[6:0];
                            d.cnt = q.cnt + ONE;
                            if (q.cnt == BYTE_LAST) begin
                                d.cnt = '0;
                                d.op  = sh_in;
                                case (sh_in)
                                    OP_READ, OP_WRITE: d.ph = PH_ADDR;
                                    OP_RD_CFG: begin
                                        d.ph    = PH_RDATA;
                                        d.first = 1'b1;
                                    end
                                    OP_WR_CFG: d.ph = PH_WCFG;
                                    default:   d.ph = PH_IDLE;
                                endcase
                            end
                        end
                        PH_ADDR: begin
                            d.addr = {q.addr[ADDR_W-2:0], si_s};
                            d.cnt  = q.cnt + ONE;
                            if (q.cnt == ADDR_LAST) begin
                                d.cnt = '0;
                                if (q.op == OP_READ) begin
                                    d.ph    = PH_RDATA;
                                    d.first = 1'b1;
                                end else begin
                                    d.ph = PH_WDATA;
                                end
                            end
                        end
                        PH_WDATA: begin
                            d.sh  = sh_in[6:0];
                            d.cnt = q.cnt + ONE;
                            if (q.cnt == BYTE_LAST) begin
                                d.cnt  = '0;
                                we_d   = 1'b1;
                                d.addr = next_addr(q.addr, q.mode);
                                if (single) d.ph = PH_IDLE;
                            end
                        end
                        PH_RDATA: begin
                            d.cnt = q.cnt + ONE;
                            if (q.cnt == BYTE_LAST) begin
                                d.cnt = '0;
                                if (q.op == OP_READ) begin
                                    if (single) begin
                                        d.ph = PH_IDLE;
                                    end else begin
                                        d.addr  = next_addr(q.addr, q.mode);
                                        d.first = 1'b1;
                                    end
                                end else begin
                                    d.first = 1'b1;
                                end
                            end
                        end
                        PH_WCFG: begin
                            d.sh  = sh_in[6:0];
                            d.cnt = q.cnt + ONE;
                            if (q.cnt == BYTE_LAST) begin
                                d.cnt      = '0;
                                d.mode     = sh_in[7:6];
                                d.hold_dis = sh_in[0];
                                cfg_wr_d   = 1'b1;
                                d.ph       = PH_IDLE;
                            end
                        end
                        default: ;
                    endcase
                end
                if (fall) begin
                    if (q.ph == PH_RDATA) begin
                        d.oe = 1'b1;
                        if (q.first) begin
                            d.so     = src[7];
                            d.out_sh = {src[6:0], 1'b0};
                            d.first  = 1'b0;
                        end else begin
                            d.so     = q.out_sh[7];
                            d.out_sh = {q.out_sh[6:0], 1'b0};
                        end
                    end else begin
                        d.oe = 1'b0;
                    end
                end
            end
            if (q.held) begin
                d.held = ~hold_n_s;
            end else begin
                d.held = ~q.hold_dis & ~hold_n_s & ~sck_s;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_addr  = q.addr;
    assign mem_we    = we_d;
    assign mem_wdata = wdata_d;
    assign so        = q.so;
    assign so_oe     = q.oe & ~q.held;
    assign held      = q.held;
    assign bit_cnt   = q.cnt;
    assign mode      = q.mode;
    assign hold_dis  = q.hold_dis;
    assign cfg_wr    = cfg_wr_d;

endmodule

// File: rtl/spi_sram_slave.sv
module spi_sram_slave #(
    parameter int ADDR_W      = 13,
    parameter int CMD_ADDR_W  = 16,
    parameter int PAGE_BYTES  = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    output logic so,
    output logic so_oe
);

    localparam int CNT_W  = $clog2(CMD_ADDR_W) + 1;
    localparam int DATA_W = 8;

    logic [3:0]        pins_s;
    logic              cs_s;
    logic              sck_s;
    logic              si_s;
    logic              hold_s;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic              held_w;
    logic [CNT_W-1:0]  bit_cnt_w;
    logic [1:0]        mode_w;
    logic              hold_dis_w;
    logic              cfg_wr_w;

    spi_sram_sync #(
        .WIDTH   (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1001)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, sck, si, hold_n}),
        .sync_o  (pins_s)
    );

    assign cs_s   = pins_s[3];
    assign sck_s  = pins_s[2];
    assign si_s   = pins_s[1];
    assign hold_s = pins_s[0];

    spi_sram_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) mem_i (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    spi_sram_ctrl #(
        .ADDR_W     (ADDR_W),
        .CMD_ADDR_W (CMD_ADDR_W),
        .PAGE_BYTES (PAGE_BYTES),
        .CNT_W      (CNT_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_s),
        .sck_s     (sck_s),
        .si_s      (si_s),
        .hold_n_s  (hold_s),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .so        (so),
        .so_oe     (so_oe),
        .held      (held_w),
        .bit_cnt   (bit_cnt_w),
        .mode      (mode_w),
        .hold_dis  (hold_dis_w),
        .cfg_wr    (cfg_wr_w)
    );

endmodule

// File: rtl/spi_sram_checker.sv
module spi_sram_checker #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             cs_sync,
    input logic             so_oe,
    input logic             held,
    input logic             mem_we,
    input logic             cfg_wr,
    input logic             hold_dis,
    input logic [CNT_W-1:0] bit_cnt,
    input logic [1:0]       mode
);

    // R10: a chip select held high leaves the output undriven
    a_r10_cs_high_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);

    // R8: while paused the output is released
    a_r8_hold_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !so_oe);

    // R8: while paused no serial clock edge advances the bit count
    a_r8_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (held && $past(held)) |-> $stable(bit_cnt));

    // R9: a pause can only start when the register enables it
    a_r9_hold_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> !$past(hold_dis));

    // R3: mode and pause bits change only on a completed register write
    a_r3_cfg_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode != $past(mode)) || (hold_dis != $past(hold_dis))) |-> $past(cfg_wr));

    // R4: array writes happen only inside a selected transfer
    a_r4_write_selected: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !cs_sync);

endmodule

bind spi_sram_slave spi_sram_checker #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .cs_sync  (cs_s),
    .so_oe    (so_oe),
    .held     (held_w),
    .mem_we   (mem_we),
    .cfg_wr   (cfg_wr_w),
    .hold_dis (hold_dis_w),
    .bit_cnt  (bit_cnt_w),
    .mode     (mode_w)
);

// File: tb/spi_sram_slave_tb.sv
module spi_sram_slave_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int WATCHDOG   = 120000;

    typedef logic [7:0] byte_q_t[$];

    logic clk    = 1'b0;
    logic rst_n  = 1'b0;
    logic cs_n   = 1'b1;
    logic sck    = 1'b0;
    logic si     = 1'b0;
    logic hold_n = 1'b1;
    logic so;
    logic so_oe;

    int total = 0;
    int bad   = 0;

    logic [7:0] exp_q[$];
    logic [7:0] act_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_sram_slave dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sck    (sck),
        .si     (si),
        .hold_n (hold_n),
        .so     (so),
        .so_oe  (so_oe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_byte(input logic [7:0] v, input string req);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx,
                         input bit chk_hiz, input string req);
        for (int i = 7; i >= 0; i--) begin
            si = tx[i];
            wait_clk(HALF);
            if (chk_hiz) check(so_oe === 1'b0, req, 32'(so_oe), 32'd0);
            rx[i] = so;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic begin_x();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic end_x();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic cmd_addr(input logic [7:0] op, input logic [15:0] a);
        logic [7:0] r;
        xbyte(op, r, 1'b1, "R4");
        xbyte(a[15:8], r, 1'b1, "R4");
        xbyte(a[7:0], r, 1'b1, "R4");
    endtask

    task automatic grab(input int n);
        logic [7:0] r;
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, r, 1'b0, "");
            act_q.push_back(r);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input byte_q_t data);
        logic [7:0] r;
        begin_x();
        cmd_addr(8'h02, a);
        foreach (data[i]) xbyte(data[i], r, 1'b0, "");
        end_x();
    endtask

    task automatic do_read(input logic [15:0] a, input int n, input bit tail_hiz,
                           input string req);
        logic [7:0] r;
        begin_x();
        cmd_addr(8'h03, a);
        grab(n);
        if (tail_hiz) xbyte(8'h00, r, 1'b1, req);
        end_x();
    endtask

    task automatic cfg_write(input logic [7:0] v);
        logic [7:0] r;
        begin_x();
        xbyte(8'h01, r, 1'b1, "R3");
        xbyte(v, r, 1'b0, "");
        end_x();
    endtask

    task automatic cfg_read(input logic [7:0] v, input string req);
        logic [7:0] r;
        expect_byte(v, req);
        begin_x();
        xbyte(8'h05, r, 1'b1, "R2");
        grab(1);
        end_x();
    endtask

    task automatic pause_pulses(input string req);
        wait_clk(HALF);
        hold_n = 1'b0;
        wait_clk(HALF);
        for (int k = 0; k < 3; k++) begin
            si  = 1'b1;
            sck = 1'b1;
            wait_clk(HALF);
            check(so_oe === 1'b0, req, 32'(so_oe), 32'd0);
            sck = 1'b0;
            wait_clk(HALF);
        end
        hold_n = 1'b1;
        wait_clk(HALF);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] a;
                logic [7:0] e;
                string      t;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (a !== e) begin
                    bad++;
                    $display("FAIL %s actual=%0h expected=%0h", t, a, e);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r;

        // R1: reset state
        wait_clk(10);
        check(so_oe === 1'b0, "R1", 32'(so_oe), 32'd0);
        rst_n = 1'b1;
        wait_clk(5);
        check(so_oe === 1'b0, "R1", 32'(so_oe), 32'd0);
        cfg_read(8'h02, "R1");

        // R3: only mode and pause-disable bits are writable
        cfg_write(8'hFF);
        cfg_read(8'hC3, "R3");
        cfg_write(8'h3C);
        cfg_read(8'h02, "R3");

        // R5 / R4: single-byte mode, upper address bits ignored
        do_write(16'h0011, '{8'h11});
        do_write(16'hE010, '{8'hA5, 8'h5A});
        expect_byte(8'hA5, "R4");
        do_read(16'h0010, 1, 1'b1, "R5");
        expect_byte(8'h11, "R5");
        do_read(16'h0011, 1, 1'b0, "");
        expect_byte(8'hA5, "R4");
        do_read(16'h2010, 1, 1'b0, "");

        // R6: page mode wraps inside a 32-byte page
        cfg_write(8'h80);
        cfg_read(8'h82, "R6");
        do_write(16'h003E, '{8'h61, 8'h62, 8'h63});
        expect_byte(8'h61, "R6");
        expect_byte(8'h62, "R6");
        expect_byte(8'h63, "R6");
        do_read(16'h003E, 3, 1'b0, "");
        expect_byte(8'h63, "R6");
        do_read(16'h0020, 1, 1'b0, "");

        // R7: sequential mode wraps over the array
        cfg_write(8'h40);
        cfg_read(8'h42, "R7");
        do_write(16'h1FFF, '{8'h71, 8'h72});
        expect_byte(8'h71, "R7");
        expect_byte(8'h72, "R7");
        do_read(16'h1FFF, 2, 1'b0, "");
        expect_byte(8'h72, "R7");
        do_read(16'h0000, 1, 1'b0, "");
        expect_byte(8'hA5, "R7");
        expect_byte(8'h11, "R7");
        do_read(16'h0010, 2, 1'b0, "");

        // R8: pause during a read and during a write
        do_write(16'h0100, '{8'h81, 8'h82, 8'h83});
        expect_byte(8'h81, "R8");
        expect_byte(8'h82, "R8");
        expect_byte(8'h83, "R8");
        begin_x();
        cmd_addr(8'h03, 16'h0100);
        grab(1);
        pause_pulses("R8");
        grab(2);
        end_x();

        begin_x();
        cmd_addr(8'h02, 16'h0200);
        xbyte(8'h91, r, 1'b0, "");
        pause_pulses("R8");
        xbyte(8'h92, r, 1'b0, "");
        end_x();
        expect_byte(8'h91, "R8");
        expect_byte(8'h92, "R8");
        do_read(16'h0200, 2, 1'b0, "");

        // R9: pause disabled, hold_n low throughout
        cfg_write(8'h41);
        hold_n = 1'b0;
        cfg_read(8'h43, "R9");
        expect_byte(8'h81, "R9");
        expect_byte(8'h82, "R9");
        expect_byte(8'h83, "R9");
        do_read(16'h0100, 3, 1'b0, "");
        hold_n = 1'b1;

        // R10: abort mid-address, then unknown instruction
        begin_x();
        xbyte(8'h03, r, 1'b1, "R10");
        for (int i = 0; i < 4; i++) begin
            si = 1'b1;
            wait_clk(HALF);
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        cs_n = 1'b1;
        wait_clk(6);
        check(so_oe === 1'b0, "R10", 32'(so_oe), 32'd0);
        wait_clk(2 * HALF);
        cfg_read(8'h43, "R10");
        begin_x();
        xbyte(8'hAB, r, 1'b1, "R10");
        xbyte(8'h05, r, 1'b1, "R10");
        xbyte(8'h00, r, 1'b1, "R10");
        end_x();
        cfg_read(8'h43, "R10");

        // R5: reserved mode behaves as single-byte
        cfg_write(8'hC0);
        cfg_read(8'hC2, "R5");
        expect_byte(8'h81, "R5");
        do_read(16'h0100, 1, 1'b1, "R5");

        wait_clk(20);
        check(exp_q.size() == 0 && act_q.size() == 0, "scoreboard",
              32'(act_q.size()), 32'(exp_q.size()));
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule